// File: doc/BRIEF.md
# Functional Unit Pool Issue Arbiter

This block decides, every cycle, which execution unit of a shared pool takes each issue request. The pool is built from unit types. Each type has a number of identical instances and a table of the operation classes it can run. For each class the table gives two latencies. The result latency is the number of cycles until the result is ready. The issue latency is the number of cycles before that instance can take another operation.

Up to `ISSUE_W` requests arrive each cycle. Each request is a lane with a valid bit and a class code. Lanes are served in order, lowest lane first. For each lane the block searches the types in the order they are listed. It grants the first type that serves the class and has a free instance, and within that type it picks the lowest-numbered free instance. The grant is registered. It names the type and the instance, and it carries the result latency so the caller can schedule completion.

A granted instance starts a busy countdown. It cannot be granted again until the countdown reaches zero. A request that finds no free instance is refused for that cycle, and the block keeps no queue. The whole pool configuration is set by parameters.

Top module: `fu_pool_arbiter`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, every lane shows `gnt_valid` = 0 and `gnt_deny` = 0, and every instance is free.
- R2: A valid request on lane l in cycle k gives, in cycle k+1, either `gnt_valid[l]` = 1 or `gnt_deny[l]` = 1, never both. A grant shows the type index, the instance index and the result latency that the configuration holds for that type and class.
- R3: Unit types are searched in ascending index order. The lowest-indexed type that serves the class and has a free instance wins. In the default pool, class 1 (multiply) goes to type 1 (latency 3) when it is free, and otherwise to type 3 (latency 5).
- R4: Within the chosen type, the lowest-numbered free instance is granted. Instances already granted to a lower lane in the same cycle count as taken. Instances at or above the type's count are never granted.
- R5: An instance granted with issue latency L is refused for the next L-1 cycles and can be granted again L cycles after its grant. In the default pool, a divide (class 2) on type 1 has result latency 20 and issue latency 19, and a multiply on type 1 has result latency 3 and issue latency 1.
- R6: A request whose class has no free serving instance gets `gnt_deny` = 1 and changes no countdown. A later request is then served as if the refused one had never been made.
- R7: A class code of `NUM_CLASSES` or above, or a class that no type serves, is always refused.
- R8: A lane with no valid request shows `gnt_valid` = 0 and `gnt_deny` = 0 one cycle later.
- R9: The default pool has four types. Type 0 is four ALUs running class 0 at 1/1. Type 1 is one multiply/divide unit. Type 2 is two memory ports running classes 3 (read) and 4 (write) at 1/1. Type 3 is one slower multiplier running class 1 at 5/2. Each pair is written as result/issue latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | ISSUE_W | One request-valid bit per lane |
| req_class | input | ISSUE_W x CLS_W | Operation class code for each lane |
| gnt_valid | output | ISSUE_W | Lane was granted (registered) |
| gnt_deny | output | ISSUE_W | Lane was refused (registered) |
| gnt_type | output | ISSUE_W x TYP_W | Index of the granted unit type |
| gnt_inst | output | ISSUE_W x INST_W | Instance index within that type |
| gnt_latency | output | ISSUE_W x LAT_W | Result latency of the granted operation |

## Verification
Two lanes ask for the same class in one cycle. A design that does not mask lower-lane grants would hand out one instance twice. A design with the wrong priority would send the second multiply somewhere other than the slower type. The divide is probed one cycle before and exactly at the end of its 19-cycle reservation; an off-by-one countdown shows up as a wrong grant or a wrong refusal at one of those two cycles. A refused request is followed by requests that must still be granted, which exposes any design that reserves a unit on a refusal. Out-of-range class codes and a lone request on the upper lane are also covered.

// File: rtl/fu_pool_pkg.sv
package fu_pool_pkg;

  localparam int DEF_TYPES   = 4;
  localparam int DEF_CLASSES = 5;

  // instances per type: ALU, mul/div, memory port, slow multiplier
  localparam int DEF_CNT [DEF_TYPES] = '{4, 1, 2, 1};

  // result latency per type and class; zero means the class is not served
  localparam int DEF_OPLAT [DEF_TYPES][DEF_CLASSES] = '{
    '{1, 0,  0, 0, 0},
    '{0, 3, 20, 0, 0},
    '{0, 0,  0, 1, 1},
    '{0, 5,  0, 0, 0}
  };

  // cycles an instance stays reserved after a grant
  localparam int DEF_ISSLAT [DEF_TYPES][DEF_CLASSES] = '{
    '{1, 0,  0, 0, 0},
    '{0, 1, 19, 0, 0},
    '{0, 0,  0, 1, 1},
    '{0, 2,  0, 0, 0}
  };

  function automatic int width_of(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/fu_unit_timer.sv
module fu_unit_timer #(
  parameter int LAT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc,
  input  logic [LAT_W-1:0] iss_lat,
  output logic             free
);

  logic [LAT_W-1:0] busy;

  always_ff @(posedge clk) begin
    if (rst)
      busy <= '0;
    else if (alloc)
      busy <= iss_lat - LAT_W'(1);
    else if (busy != '0)
      busy <= busy - LAT_W'(1);
  end

  assign free = (busy == '0);

  // R5: the picker only reserves an instance whose countdown is idle
  a_r5_alloc_only_when_free: assert property (@(posedge clk) disable iff (rst)
    alloc |-> busy == '0);

  // R5: a reservation longer than one cycle blocks the very next cycle
  a_r5_hold_after_grant: assert property (@(posedge clk) disable iff (rst)
    (alloc && iss_lat > LAT_W'(1)) |=> !free);

endmodule

// File: rtl/fu_grant_picker.sv
module fu_grant_picker #(
  parameter int NUM_TYPES   = 4,
  parameter int NUM_CLASSES = 5,
  parameter int MAX_INST    = 4,
  parameter int ISSUE_W     = 2,
  parameter int LAT_W       = 6,
  parameter int CLS_W       = 3,
  parameter int TYP_W       = 2,
  parameter int INST_W      = 2,
  parameter int TYPE_CNT [NUM_TYPES] = fu_pool_pkg::DEF_CNT,
  parameter int OP_LAT  [NUM_TYPES][NUM_CLASSES] = fu_pool_pkg::DEF_OPLAT,
  parameter int ISS_LAT [NUM_TYPES][NUM_CLASSES] = fu_pool_pkg::DEF_ISSLAT,
  localparam int NUM_UNITS = NUM_TYPES * MAX_INST
) (
  input  logic [ISSUE_W-1:0]                 req_valid,
  input  logic [ISSUE_W-1:0][CLS_W-1:0]      req_class,
  input  logic [NUM_UNITS-1:0]               unit_free,
  output logic [NUM_UNITS-1:0]               unit_alloc,
  output logic [NUM_UNITS-1:0][LAT_W-1:0]    unit_iss,
  output logic [ISSUE_W-1:0]                 pick_valid,
  output logic [ISSUE_W-1:0]                 pick_deny,
  output logic [ISSUE_W-1:0][TYP_W-1:0]      pick_type,
  output logic [ISSUE_W-1:0][INST_W-1:0]     pick_inst,
  output logic [ISSUE_W-1:0][LAT_W-1:0]      pick_lat
);

  always_comb begin : pick
    logic [NUM_UNITS-1:0] avail;
    logic                 found;
    int                   cls;
    avail      = unit_free;
    unit_alloc = '0;
    unit_iss   = '0;
    pick_valid = '0;
    pick_deny  = '0;
    pick_type  = '0;
    pick_inst  = '0;
    pick_lat   = '0;
    for (int l = 0; l < ISSUE_W; l++) begin
      found = 1'b0;
      cls   = int'(req_class[l]);
      if (req_valid[l] && cls < NUM_CLASSES) begin
        for (int t = 0; t < NUM_TYPES; t++) begin
          for (int i = 0; i < MAX_INST; i++) begin
            if (!found && i < TYPE_CNT[t] && OP_LAT[t][cls] != 0 &&
                avail[t*MAX_INST + i]) begin
              found                     = 1'b1;
              avail[t*MAX_INST + i]     = 1'b0;
              unit_alloc[t*MAX_INST + i] = 1'b1;
              unit_iss[t*MAX_INST + i]  = LAT_W'(ISS_LAT[t][cls]);
              pick_type[l]              = TYP_W'(t);
              pick_inst[l]              = INST_W'(i);
              pick_lat[l]               = LAT_W'(OP_LAT[t][cls]);
            end
          end
        end
      end
      pick_valid[l] = found;
      pick_deny[l]  = req_valid[l] && !found;
    end
  end

endmodule

// File: rtl/fu_pool_arbiter.sv
module fu_pool_arbiter #(
  parameter int NUM_TYPES   = fu_pool_pkg::DEF_TYPES,
  parameter int NUM_CLASSES = fu_pool_pkg::DEF_CLASSES,
  parameter int MAX_INST    = 4,
  parameter int ISSUE_W     = 2,
  parameter int LAT_W       = 6,
  parameter int TYPE_CNT [NUM_TYPES] = fu_pool_pkg::DEF_CNT,
  parameter int OP_LAT  [NUM_TYPES][NUM_CLASSES] = fu_pool_pkg::DEF_OPLAT,
  parameter int ISS_LAT [NUM_TYPES][NUM_CLASSES] = fu_pool_pkg::DEF_ISSLAT,
  localparam int CLS_W     = fu_pool_pkg::width_of(NUM_CLASSES),
  localparam int TYP_W     = fu_pool_pkg::width_of(NUM_TYPES),
  localparam int INST_W    = fu_pool_pkg::width_of(MAX_INST),
  localparam int NUM_UNITS = NUM_TYPES * MAX_INST
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [ISSUE_W-1:0]               req_valid,
  input  logic [ISSUE_W-1:0][CLS_W-1:0]    req_class,
  output logic [ISSUE_W-1:0]               gnt_valid,
  output logic [ISSUE_W-1:0]               gnt_deny,
  output logic [ISSUE_W-1:0][TYP_W-1:0]    gnt_type,
  output logic [ISSUE_W-1:0][INST_W-1:0]   gnt_inst,
  output logic [ISSUE_W-1:0][LAT_W-1:0]    gnt_latency
);

  logic [NUM_UNITS-1:0]            unit_free;
  logic [NUM_UNITS-1:0]            unit_alloc;
  logic [NUM_UNITS-1:0][LAT_W-1:0] unit_iss;
  logic [ISSUE_W-1:0]              pick_valid;
  logic [ISSUE_W-1:0]              pick_deny;
  logic [ISSUE_W-1:0][TYP_W-1:0]   pick_type;
  logic [ISSUE_W-1:0][INST_W-1:0]  pick_inst;
  logic [ISSUE_W-1:0][LAT_W-1:0]   pick_lat;

  fu_grant_picker #(
    .NUM_TYPES(NUM_TYPES), .NUM_CLASSES(NUM_CLASSES), .MAX_INST(MAX_INST),
    .ISSUE_W(ISSUE_W), .LAT_W(LAT_W), .CLS_W(CLS_W), .TYP_W(TYP_W),
    .INST_W(INST_W), .TYPE_CNT(TYPE_CNT), .OP_LAT(OP_LAT), .ISS_LAT(ISS_LAT)
  ) u_picker (
    .req_valid(req_valid), .req_class(req_class), .unit_free(unit_free),
    .unit_alloc(unit_alloc), .unit_iss(unit_iss),
    .pick_valid(pick_valid), .pick_deny(pick_deny), .pick_type(pick_type),
    .pick_inst(pick_inst), .pick_lat(pick_lat)
  );

  for (genvar t = 0; t < NUM_TYPES; t++) begin : g_type
    for (genvar i = 0; i < MAX_INST; i++) begin : g_inst
      if (i < TYPE_CNT[t]) begin : g_real
        fu_unit_timer #(.LAT_W(LAT_W)) u_timer (
          .clk(clk), .rst(rst),
          .alloc(unit_alloc[t*MAX_INST + i]),
          .iss_lat(unit_iss[t*MAX_INST + i]),
          .free(unit_free[t*MAX_INST + i])
        );
      end else begin : g_absent
        assign unit_free[t*MAX_INST + i] = 1'b0;
        // R4: slots beyond the type's count are never touched
        a_r4_absent_unit_idle: assert property (@(posedge clk) disable iff (rst)
          !unit_alloc[t*MAX_INST + i] && unit_iss[t*MAX_INST + i] == '0);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_valid   <= '0;
      gnt_deny    <= '0;
      gnt_type    <= '0;
      gnt_inst    <= '0;
      gnt_latency <= '0;
    end else begin
      gnt_valid   <= pick_valid;
      gnt_deny    <= pick_deny;
      gnt_type    <= pick_type;
      gnt_inst    <= pick_inst;
      gnt_latency <= pick_lat;
    end
  end

  for (genvar l = 0; l < ISSUE_W; l++) begin : g_lane_chk
    // R2: each valid request is answered exactly once in the next cycle
    a_r2_one_answer: assert property (@(posedge clk) disable iff (rst)
      req_valid[l] |=> (gnt_valid[l] ^ gnt_deny[l]));
    // R2: a grant always reports a real result latency
    a_r2_latency_set: assert property (@(posedge clk) disable iff (rst)
      gnt_valid[l] |-> gnt_latency[l] != '0);
    // R8: an idle lane stays quiet
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
      !req_valid[l] |=> (!gnt_valid[l] && !gnt_deny[l]));
    // R7: out-of-range class codes are refused
    a_r7_bad_class_denied: assert property (@(posedge clk) disable iff (rst)
      (req_valid[l] && int'(req_class[l]) >= NUM_CLASSES) |=> gnt_deny[l]);
  end

endmodule

// File: tb/tb_fu_pool_arbiter.sv
module tb_fu_pool_arbiter;

  localparam int CLK_PERIOD = 10;
  localparam int ISSUE_W = 2;
  localparam int CLS_W   = 3;
  localparam int TYP_W   = 2;
  localparam int INST_W  = 2;
  localparam int LAT_W   = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ISSUE_W-1:0]             req_valid = '0;
  logic [ISSUE_W-1:0][CLS_W-1:0]  req_class = '0;
  logic [ISSUE_W-1:0]             gnt_valid;
  logic [ISSUE_W-1:0]             gnt_deny;
  logic [ISSUE_W-1:0][TYP_W-1:0]  gnt_type;
  logic [ISSUE_W-1:0][INST_W-1:0] gnt_inst;
  logic [ISSUE_W-1:0][LAT_W-1:0]  gnt_latency;

  fu_pool_arbiter dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_class(req_class),
    .gnt_valid(gnt_valid), .gnt_deny(gnt_deny), .gnt_type(gnt_type),
    .gnt_inst(gnt_inst), .gnt_latency(gnt_latency)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // kind: 0 quiet, 1 grant, 2 refusal (matches {deny,valid})
  typedef struct {
    int    kind;
    int    typ;
    int    inst;
    int    lat;
    int    due;
    int    lane;
    string tag;
  } exp_t;

  exp_t sbq[$];
  int   cyc = 0;
  int   n_tests = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input bit ok, input string what,
                       input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)",
               tag, what, act, expv, cyc);
    end
  endtask

  function automatic exp_t xg(input int t, input int i, input int lat, input string tag);
    exp_t e;
    e.kind = 1; e.typ = t; e.inst = i; e.lat = lat; e.tag = tag;
    e.due = 0; e.lane = 0;
    return e;
  endfunction

  function automatic exp_t xd(input string tag);
    exp_t e;
    e = xg(0, 0, 0, tag);
    e.kind = 2;
    return e;
  endfunction

  function automatic exp_t xn(input string tag);
    exp_t e;
    e = xg(0, 0, 0, tag);
    e.kind = 0;
    return e;
  endfunction

  // monitor: compare each lane result in the cycle it is due
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].due == cyc) begin
      exp_t e;
      int   l;
      int   ak;
      e  = sbq.pop_front();
      l  = e.lane;
      ak = int'({gnt_deny[l], gnt_valid[l]});
      check(e.tag, ak == e.kind, $sformatf("lane%0d kind", l), ak, e.kind);
      if (e.kind == 1 && ak == 1) begin
        check(e.tag, int'(gnt_type[l]) == e.typ, $sformatf("lane%0d type", l),
              int'(gnt_type[l]), e.typ);
        check(e.tag, int'(gnt_inst[l]) == e.inst, $sformatf("lane%0d inst", l),
              int'(gnt_inst[l]), e.inst);
        check(e.tag, int'(gnt_latency[l]) == e.lat, $sformatf("lane%0d latency", l),
              int'(gnt_latency[l]), e.lat);
      end
    end
  end

  // driver: called at a falling edge, pushes expectations for the next cycle
  task automatic step(input bit v0, input int c0, input exp_t e0,
                      input bit v1, input int c1, input exp_t e1);
    exp_t a;
    exp_t b;
    req_valid[0] = v0;
    req_class[0] = CLS_W'(c0);
    req_valid[1] = v1;
    req_class[1] = CLS_W'(c1);
    a = e0; a.lane = 0; a.due = cyc + 1;
    b = e1; b.lane = 1; b.due = cyc + 1;
    sbq.push_back(a);
    sbq.push_back(b);
    @(negedge clk);
  endtask

  task automatic check_quiet(input string tag);
    for (int l = 0; l < ISSUE_W; l++) begin
      check(tag, gnt_valid[l] == 1'b0, $sformatf("lane%0d valid", l), int'(gnt_valid[l]), 0);
      check(tag, gnt_deny[l] == 1'b0, $sformatf("lane%0d deny", l), int'(gnt_deny[l]), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_quiet("R1 in reset");
    rst = 1'b0;
    @(negedge clk);
    check_quiet("R1 after reset");

    // classes: 0 ALU, 1 MUL, 2 DIV, 3 RD, 4 WR
    step(1, 0, xg(0, 0, 1, "R4 R9 alu lane0"), 1, 0, xg(0, 1, 1, "R4 alu lane1"));
    step(1, 0, xg(0, 0, 1, "R5 alu reuse"),    1, 0, xg(0, 1, 1, "R5 alu reuse"));
    step(1, 3, xg(2, 0, 1, "R9 mem read"),     1, 4, xg(2, 1, 1, "R4 mem write"));
    step(1, 1, xg(1, 0, 3, "R2 R9 mul"),       1, 1, xg(3, 0, 5, "R3 mul fallback"));
    step(1, 1, xg(1, 0, 3, "R5 mul iss1"),     1, 1, xd("R6 slow mul held"));
    // divide at cycle k
    step(1, 2, xg(1, 0, 20, "R5 R9 div"),      0, 0, xn("R8 idle lane"));
    step(1, 1, xg(3, 0, 5, "R3 mul to slow"),  1, 2, xd("R6 div busy"));
    for (int n = 0; n < 16; n++)
      step(0, 0, xn("R8 idle"), 0, 0, xn("R8 idle"));
    // cycle k+18: still reserved
    step(1, 2, xd("R5 div one early"),          1, 1, xg(3, 0, 5, "R3 mul slow"));
    // cycle k+19: reservation over; refusal left no trace
    step(1, 2, xg(1, 0, 20, "R5 R6 div again"), 1, 1, xd("R6 slow mul busy"));
    step(1, 5, xd("R7 class 5"),                1, 7, xd("R7 class 7"));
    step(0, 0, xn("R8 lane0 idle"),             1, 0, xg(0, 0, 1, "R4 lone lane1"));
    step(0, 0, xn("R8 end"),                    0, 0, xn("R8 end"));
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog R2: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule